// File: doc/BRIEF.md
# Process-Tagged Set-Associative Translation Buffer

This block holds a small set of page-table entries so that a virtual page number is turned into a physical page number in the same cycle it is presented. Every way of the set chosen by the low bits of the virtual page number is compared at once. An entry matches only when it is valid, its stored upper page bits equal those of the request, and its stored process identifier equals the current-process input. Because entries carry the identifier, the buffer can stay full across context switches.

Each entry also holds three permission bits. A matching entry whose permissions forbid the requested kind of access raises a protection-fault output in place of a hit. Hits update status bits that are kept only in the buffer: any hit marks the entry referenced, and a write hit marks it dirty.

After a miss, the surrounding logic loads the entry through the fill port. The entry is tagged with the current process identifier. It goes to the lowest free way of its set. If the set is full, a way is picked by a free-running pseudo-random register. When a valid entry is pushed out, its page number, process identifier and status bits are presented for one cycle so they can be written back to the page table. A flush input drops every entry in one cycle.

Top module: `ptx_tlb`

## Requirements
- R1: With `lookupValid` high, `hit` and `ppnOut` are valid in the same cycle, with no clock edge in between. A match needs a valid entry whose stored upper page bits and process identifier both equal the request. `ppnOut` is 0 whenever `hit` is low.
- R2: An entry filled under one process identifier does not match a lookup made under another. Two processes may hold the same virtual page at once, each with its own physical page. Changing `curPid` back brings the entry back with no refill.
- R3: `fillPerm` bit 0 allows read, bit 1 allows write and bit 2 allows execute. `accessKind` encodes 0 as read, 1 as write and 2 as execute; 3 is never allowed. A matching lookup whose kind is not allowed raises `protFault`, keeps `hit` and `miss` low, and leaves the entry's status bits unchanged.
- R4: With `lookupValid` high and no matching entry, `miss` is high and `hit` and `protFault` are low. With `lookupValid` low, all three outputs are low.
- R5: The set index is the low log2(SETS) bits of the virtual page number. A fill into a set that has an invalid way takes the lowest invalid way and produces no writeback.
- R6: A fill into a full set, with no entry for the same page and process, replaces a way chosen by a free-running LFSR. In the cycle after the fill edge, `wbValid` is high for one cycle. It carries the victim's page number, process identifier, dirty bit and referenced bit. The other entries of the set still hit, and the victim misses.
- R7: At the edge that ends a hit cycle, the entry's referenced bit is set. If the access is a write, its dirty bit is also set. A fill loads an entry with both bits clear. These bits are the ones reported on eviction.
- R8: A fill for a page and process already present overwrites that same way in place. The new physical page and permissions take effect, the status bits are cleared, and no writeback occurs. At most one way ever matches a lookup.
- R9: `flushAll` invalidates every entry at one edge, and any fill in that same cycle is ignored. Afterwards all lookups miss, and fills produce no writeback until a set is full again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | Translation request this cycle |
| lookupVpn | input | VPN_W | Virtual page number to translate |
| accessKind | input | 2 | 0 read, 1 write, 2 execute, 3 none allowed |
| curPid | input | PID_W | Current process identifier, used for lookups and fills |
| flushAll | input | 1 | Invalidate every entry |
| fillValid | input | 1 | Load an entry this cycle |
| fillVpn | input | VPN_W | Virtual page number of the loaded entry |
| fillPpn | input | PPN_W | Physical page number of the loaded entry |
| fillPerm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| hit | output | 1 | Allowed match |
| miss | output | 1 | No matching entry |
| protFault | output | 1 | Match with a forbidden access kind |
| ppnOut | output | PPN_W | Translated physical page, 0 unless hit |
| wbValid | output | 1 | One-cycle strobe for an evicted valid entry |
| wbVpn | output | VPN_W | Evicted virtual page number |
| wbPid | output | PID_W | Evicted process identifier |
| wbDirty | output | 1 | Evicted dirty bit |
| wbRef | output | 1 | Evicted referenced bit |

## Verification
The bench builds the block with SETS=2, WAYS=4, VPN_W=12, PPN_W=12 and PID_W=3. Bit 0 of the page number therefore picks the set, and one set fills after only four loads. That makes several random evictions reachable within a few dozen cycles. Evictions are checked against a bench-side model that records each entry's status, so the test does not depend on which way the LFSR picks. The narrow identifier still lets two processes share one page number inside the same set.

// File: rtl/ptx_tlb_pkg.sv
package ptx_tlb_pkg;

  // Access kinds presented with a lookup
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_NONE  = 2'd3
  } accKind_t;

  // Permission bit positions
  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic flush;
    logic fill;
    logic evict;
    logic touch;
    logic touchWrite;
  } tlbStrobe_t;

endpackage

// File: rtl/ptx_tlb_dp.sv
module ptx_tlb_dp
  import ptx_tlb_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int PID_W = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  tlbStrobe_t       strobe,
  input  logic [VPN_W-1:0] lookupVpn,
  input  logic [PID_W-1:0] curPid,
  input  logic [WAY_W-1:0] hitWay,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PPN_W-1:0] fillPpn,
  input  logic [2:0]       fillPerm,
  input  logic [WAY_W-1:0] fillWay,
  output logic [WAYS-1:0]  lookMatch,
  output logic [PPN_W-1:0] matchPpn,
  output logic [2:0]       matchPerm,
  output logic [WAYS-1:0]  fillSetValid,
  output logic [WAYS-1:0]  fillSetMatch,
  output logic             wbValid,
  output logic [VPN_W-1:0] wbVpn,
  output logic [PID_W-1:0] wbPid,
  output logic             wbDirty,
  output logic             wbRef
);

  localparam int TAG_W = VPN_W - SET_W;

  logic [SETS-1:0][WAYS-1:0] validQ, dirtyQ, refQ;
  logic [TAG_W-1:0] tagQ  [SETS][WAYS];
  logic [PID_W-1:0] pidQ  [SETS][WAYS];
  logic [PPN_W-1:0] ppnQ  [SETS][WAYS];
  logic [2:0]       permQ [SETS][WAYS];

  logic [SET_W-1:0] lookIdx, fillIdx;
  logic [TAG_W-1:0] lookTag, fillTag;

  assign lookIdx = lookupVpn[SET_W-1:0];
  assign lookTag = lookupVpn[VPN_W-1:SET_W];
  assign fillIdx = fillVpn[SET_W-1:0];
  assign fillTag = fillVpn[VPN_W-1:SET_W];

  // Parallel compare across every way of both addressed sets
  for (genvar w = 0; w < WAYS; w++) begin : gWay
    assign lookMatch[w] = validQ[lookIdx][w] && (tagQ[lookIdx][w] == lookTag)
                          && (pidQ[lookIdx][w] == curPid);
    assign fillSetValid[w] = validQ[fillIdx][w];
    assign fillSetMatch[w] = validQ[fillIdx][w] && (tagQ[fillIdx][w] == fillTag)
                             && (pidQ[fillIdx][w] == curPid);
  end

  // One-hot select of the matching entry's payload
  always_comb begin
    matchPpn  = '0;
    matchPerm = '0;
    for (int w = 0; w < WAYS; w++) begin
      matchPpn  = matchPpn  | (ppnQ[lookIdx][w]  & {PPN_W{lookMatch[w]}});
      matchPerm = matchPerm | (permQ[lookIdx][w] & {3{lookMatch[w]}});
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ  <= '0;
      dirtyQ  <= '0;
      refQ    <= '0;
      wbValid <= 1'b0;
      wbVpn   <= '0;
      wbPid   <= '0;
      wbDirty <= 1'b0;
      wbRef   <= 1'b0;
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          tagQ[s][w]  <= '0;
          pidQ[s][w]  <= '0;
          ppnQ[s][w]  <= '0;
          permQ[s][w] <= '0;
        end
      end
    end else begin
      wbValid <= 1'b0;
      if (strobe.flush) begin
        validQ <= '0;
      end else begin
        if (strobe.touch) begin
          refQ[lookIdx][hitWay] <= 1'b1;
          if (strobe.touchWrite) dirtyQ[lookIdx][hitWay] <= 1'b1;
        end
        // A fill written later wins over a touch of the same entry
        if (strobe.fill) begin
          validQ[fillIdx][fillWay] <= 1'b1;
          dirtyQ[fillIdx][fillWay] <= 1'b0;
          refQ[fillIdx][fillWay]   <= 1'b0;
          tagQ[fillIdx][fillWay]   <= fillTag;
          pidQ[fillIdx][fillWay]   <= curPid;
          ppnQ[fillIdx][fillWay]   <= fillPpn;
          permQ[fillIdx][fillWay]  <= fillPerm;
          if (strobe.evict) begin
            wbValid <= 1'b1;
            wbVpn   <= {tagQ[fillIdx][fillWay], fillIdx};
            wbPid   <= pidQ[fillIdx][fillWay];
            wbDirty <= dirtyQ[fillIdx][fillWay];
            wbRef   <= refQ[fillIdx][fillWay];
          end
        end
      end
    end
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lookMatch)); // R8
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> (lookMatch == '0)); // R9
  AST_WB_FROM_EVICT: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> $past(strobe.evict)); // R6

endmodule

// File: rtl/ptx_tlb_ctrl.sv
module ptx_tlb_ctrl
  import ptx_tlb_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic [1:0]       accessKind,
  input  logic             flushAll,
  input  logic             fillValid,
  input  logic [WAYS-1:0]  lookMatch,
  input  logic [2:0]       matchPerm,
  input  logic [WAYS-1:0]  fillSetValid,
  input  logic [WAYS-1:0]  fillSetMatch,
  output tlbStrobe_t       strobe,
  output logic [WAY_W-1:0] hitWay,
  output logic [WAY_W-1:0] fillWay,
  output logic             hit,
  output logic             miss,
  output logic             protFault
);

  // Victim source; eight bits cover any WAYS up to 256 (power of two)
  localparam int LFSR_W = 8;
  logic [LFSR_W-1:0] lfsrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lfsrQ <= 8'h5A;
    else       lfsrQ <= {lfsrQ[LFSR_W-2:0], lfsrQ[7] ^ lfsrQ[5] ^ lfsrQ[4] ^ lfsrQ[3]};
  end

  logic hitAny, allowed, setFull, sameEntry;
  logic [WAY_W-1:0] freeWay, sameWay;

  always_comb begin
    unique case (accKind_t'(accessKind))
      ACC_READ:  allowed = matchPerm[PERM_R];
      ACC_WRITE: allowed = matchPerm[PERM_W];
      ACC_EXEC:  allowed = matchPerm[PERM_X];
      default:   allowed = 1'b0;
    endcase
  end

  always_comb begin
    hitWay  = '0;
    sameWay = '0;
    freeWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (lookMatch[w])     hitWay  = WAY_W'(w);
      if (fillSetMatch[w])  sameWay = WAY_W'(w);
      if (!fillSetValid[w]) freeWay = WAY_W'(w);
    end
  end

  assign hitAny    = |lookMatch;
  assign setFull   = &fillSetValid;
  assign sameEntry = |fillSetMatch;

  assign hit       = lookupValid && hitAny && allowed;
  assign protFault = lookupValid && hitAny && !allowed;
  assign miss      = lookupValid && !hitAny;

  always_comb begin
    if (sameEntry)     fillWay = sameWay;
    else if (!setFull) fillWay = freeWay;
    else               fillWay = lfsrQ[WAY_W-1:0];
  end

  always_comb begin
    strobe.flush      = flushAll;
    strobe.fill       = fillValid && !flushAll;
    strobe.evict      = fillValid && !flushAll && !sameEntry && setFull;
    strobe.touch      = hit && !flushAll;
    strobe.touchWrite = (accKind_t'(accessKind) == ACC_WRITE);
  end

  AST_HIT_NOT_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    !(hit && protFault)); // R3
  AST_MISS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    miss |-> (!hit && !protFault)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |-> !(hit || miss || protFault)); // R4
  AST_EVICT_ONLY_FULL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.evict |-> (&fillSetValid)); // R5

endmodule

// File: rtl/ptx_tlb.sv
module ptx_tlb
  import ptx_tlb_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int PID_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic [VPN_W-1:0] lookupVpn,
  input  logic [1:0]       accessKind,
  input  logic [PID_W-1:0] curPid,
  input  logic             flushAll,
  input  logic             fillValid,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PPN_W-1:0] fillPpn,
  input  logic [2:0]       fillPerm,
  output logic             hit,
  output logic             miss,
  output logic             protFault,
  output logic [PPN_W-1:0] ppnOut,
  output logic             wbValid,
  output logic [VPN_W-1:0] wbVpn,
  output logic [PID_W-1:0] wbPid,
  output logic             wbDirty,
  output logic             wbRef
);

  localparam int WAY_W = $clog2(WAYS);

  tlbStrobe_t       strobe;
  logic [WAY_W-1:0] hitWay, fillWay;
  logic [WAYS-1:0]  lookMatch, fillSetValid, fillSetMatch;
  logic [PPN_W-1:0] matchPpn;
  logic [2:0]       matchPerm;

  ptx_tlb_ctrl #(.WAYS(WAYS)) uCtrl (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .accessKind(accessKind),
    .flushAll(flushAll), .fillValid(fillValid), .lookMatch(lookMatch),
    .matchPerm(matchPerm), .fillSetValid(fillSetValid), .fillSetMatch(fillSetMatch),
    .strobe(strobe), .hitWay(hitWay), .fillWay(fillWay),
    .hit(hit), .miss(miss), .protFault(protFault)
  );

  ptx_tlb_dp #(
    .SETS(SETS), .WAYS(WAYS), .VPN_W(VPN_W), .PPN_W(PPN_W), .PID_W(PID_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lookupVpn(lookupVpn), .curPid(curPid),
    .hitWay(hitWay), .fillVpn(fillVpn), .fillPpn(fillPpn), .fillPerm(fillPerm),
    .fillWay(fillWay), .lookMatch(lookMatch), .matchPpn(matchPpn),
    .matchPerm(matchPerm), .fillSetValid(fillSetValid), .fillSetMatch(fillSetMatch),
    .wbValid(wbValid), .wbVpn(wbVpn), .wbPid(wbPid), .wbDirty(wbDirty), .wbRef(wbRef)
  );

  assign ppnOut = hit ? matchPpn : '0;

endmodule

// File: tb/ptx_tlb_test.sv
`timescale 1ns/1ps
module ptx_tlb_test;

  localparam int SETS = 2, WAYS = 4, VPN_W = 12, PPN_W = 12, PID_W = 3;
  localparam int MDEPTH = 16;
  localparam int K_LOOK = 0, K_NOWB = 1, K_ANYWB = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic lookupValid = 1'b0, flushAll = 1'b0, fillValid = 1'b0;
  logic [VPN_W-1:0] lookupVpn = '0, fillVpn = '0;
  logic [1:0] accessKind = '0;
  logic [PID_W-1:0] curPid = '0;
  logic [PPN_W-1:0] fillPpn = '0;
  logic [2:0] fillPerm = '0;
  logic hit, miss, protFault, wbValid, wbDirty, wbRef;
  logic [PPN_W-1:0] ppnOut;
  logic [VPN_W-1:0] wbVpn;
  logic [PID_W-1:0] wbPid;

  always #2.5 clk = ~clk;

  ptx_tlb #(.SETS(SETS), .WAYS(WAYS), .VPN_W(VPN_W), .PPN_W(PPN_W), .PID_W(PID_W)) uut (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVpn(lookupVpn),
    .accessKind(accessKind), .curPid(curPid), .flushAll(flushAll), .fillValid(fillValid),
    .fillVpn(fillVpn), .fillPpn(fillPpn), .fillPerm(fillPerm), .hit(hit), .miss(miss),
    .protFault(protFault), .ppnOut(ppnOut), .wbValid(wbValid), .wbVpn(wbVpn),
    .wbPid(wbPid), .wbDirty(wbDirty), .wbRef(wbRef)
  );

  typedef struct {
    int    kind;
    logic  eHit, eMiss, eFault;
    int    ePpn;
    string req;
  } expItem_t;

  expItem_t expQ[$];
  int total = 0, failed = 0;
  bit done = 1'b0;

  // Reference model of resident entries
  logic [VPN_W-1:0] mVpn  [MDEPTH];
  logic [PID_W-1:0] mPid  [MDEPTH];
  logic [PPN_W-1:0] mPpn  [MDEPTH];
  logic [2:0]       mPerm [MDEPTH];
  logic             mDirty[MDEPTH], mRef[MDEPTH], mLive[MDEPTH];
  logic [VPN_W-1:0] lastEvVpn = '0;
  logic [PID_W-1:0] lastEvPid = '0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int findEntry(input logic [VPN_W-1:0] v, input logic [PID_W-1:0] p);
    for (int i = 0; i < MDEPTH; i++)
      if (mLive[i] && mVpn[i] == v && mPid[i] == p) return i;
    return -1;
  endfunction

  function automatic int setCount(input logic [VPN_W-1:0] v);
    int n = 0;
    for (int i = 0; i < MDEPTH; i++)
      if (mLive[i] && mVpn[i][0] == v[0]) n++;
    return n;
  endfunction

  // Monitor: compares results half a cycle after the driver sets up
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      if (it.kind == K_LOOK) begin
        chk(hit == it.eHit, it.req, "hit", int'(hit), int'(it.eHit));
        chk(miss == it.eMiss, it.req, "miss", int'(miss), int'(it.eMiss));
        chk(protFault == it.eFault, it.req, "protFault", int'(protFault), int'(it.eFault));
        chk(int'(ppnOut) == it.ePpn, it.req, "ppnOut", int'(ppnOut), it.ePpn);
      end else if (it.kind == K_NOWB) begin
        chk(wbValid == 1'b0, it.req, "wbValid", int'(wbValid), 0);
      end else begin
        int idx;
        chk(wbValid == 1'b1, it.req, "wbValid", int'(wbValid), 1);
        idx = findEntry(wbVpn, wbPid);
        chk(idx >= 0, it.req, "evicted entry resident", int'(wbVpn), idx);
        if (idx >= 0) begin
          chk(wbDirty == mDirty[idx], "R7", "wbDirty", int'(wbDirty), int'(mDirty[idx]));
          chk(wbRef == mRef[idx], "R7", "wbRef", int'(wbRef), int'(mRef[idx]));
          mLive[idx] = 1'b0;
        end
        lastEvVpn = wbVpn;
        lastEvPid = wbPid;
      end
    end
  end

  // Driver: one lookup, one cycle
  task automatic doLookup(input bit v, input logic [VPN_W-1:0] vpn, input logic [PID_W-1:0] pid,
                          input logic [1:0] acc, input string req);
    expItem_t it;
    int idx;
    bit ok;
    it.kind = K_LOOK; it.req = req;
    it.eHit = 1'b0; it.eMiss = 1'b0; it.eFault = 1'b0; it.ePpn = 0;
    if (v) begin
      idx = findEntry(vpn, pid);
      if (idx < 0) it.eMiss = 1'b1;
      else begin
        ok = (acc == 2'd0) ? mPerm[idx][0] : (acc == 2'd1) ? mPerm[idx][1] :
             (acc == 2'd2) ? mPerm[idx][2] : 1'b0;
        if (ok) begin
          it.eHit = 1'b1; it.ePpn = int'(mPpn[idx]);
          mRef[idx] = 1'b1;
          if (acc == 2'd1) mDirty[idx] = 1'b1;
        end else it.eFault = 1'b1;
      end
    end
    lookupValid = v; lookupVpn = vpn; curPid = pid; accessKind = acc;
    expQ.push_back(it);
    @(posedge clk); #1;
    lookupValid = 1'b0;
  endtask

  task automatic doFill(input logic [VPN_W-1:0] vpn, input logic [PID_W-1:0] pid,
                        input logic [PPN_W-1:0] ppn, input logic [2:0] perm, input string req);
    expItem_t it;
    int idx;
    it.kind = K_NOWB; it.req = req;
    it.eHit = 1'b0; it.eMiss = 1'b0; it.eFault = 1'b0; it.ePpn = 0;
    idx = findEntry(vpn, pid);
    if (idx >= 0) mLive[idx] = 1'b0;
    else if (setCount(vpn) == WAYS) it.kind = K_ANYWB;
    fillValid = 1'b1; fillVpn = vpn; curPid = pid; fillPpn = ppn; fillPerm = perm;
    @(posedge clk); #1;
    fillValid = 1'b0;
    expQ.push_back(it);
    @(negedge clk); #0.5;
    for (int i = 0; i < MDEPTH; i++) begin
      if (!mLive[i] && findEntry(vpn, pid) < 0) begin
        mLive[i] = 1'b1; mVpn[i] = vpn; mPid[i] = pid; mPpn[i] = ppn;
        mPerm[i] = perm; mDirty[i] = 1'b0; mRef[i] = 1'b0;
      end
    end
    @(posedge clk); #1;
  endtask

  task automatic doFlush(input bit withFill);
    flushAll = 1'b1;
    if (withFill) begin
      fillValid = 1'b1; fillVpn = 12'h040; curPid = 3'd1; fillPpn = 12'h777; fillPerm = 3'b111;
    end
    @(posedge clk); #1;
    flushAll = 1'b0; fillValid = 1'b0;
    for (int i = 0; i < MDEPTH; i++) mLive[i] = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      failed++; total++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MDEPTH; i++) begin
      mLive[i] = 1'b0; mVpn[i] = '0; mPid[i] = '0; mPpn[i] = '0;
      mPerm[i] = '0; mDirty[i] = 1'b0; mRef[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(hit == 1'b0 && miss == 1'b0 && protFault == 1'b0, "R4", "reset outputs",
        int'({hit, miss, protFault}), 0);
    chk(wbValid == 1'b0, "R6", "reset wbValid", int'(wbValid), 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    @(posedge clk); #1;

    doLookup(1, 12'h010, 3'd1, 2'd0, "R4");            // empty buffer misses
    doFill(12'h010, 3'd1, 12'h0A1, 3'b011, "R5");       // free way, no writeback
    doLookup(1, 12'h010, 3'd1, 2'd0, "R1");
    doLookup(1, 12'h010, 3'd2, 2'd0, "R2");             // other process misses
    doLookup(1, 12'h010, 3'd1, 2'd2, "R3");             // execute not allowed
    doLookup(1, 12'h010, 3'd1, 2'd3, "R3");             // kind 3 never allowed
    doLookup(0, 12'h010, 3'd1, 2'd0, "R4");             // idle request quiet
    doFill(12'h010, 3'd2, 12'h0B2, 3'b111, "R2");
    doLookup(1, 12'h010, 3'd2, 2'd0, "R2");
    doLookup(1, 12'h010, 3'd1, 2'd1, "R2");             // back to pid 1, write hit
    doFill(12'h010, 3'd1, 12'h0C3, 3'b001, "R8");       // in-place refill
    doLookup(1, 12'h010, 3'd1, 2'd0, "R8");
    doLookup(1, 12'h010, 3'd1, 2'd1, "R3");             // write now forbidden
    doFill(12'h012, 3'd1, 12'h0D4, 3'b101, "R5");
    doFill(12'h014, 3'd1, 12'h0E5, 3'b011, "R5");       // set 0 now full
    doFill(12'h011, 3'd1, 12'h0F6, 3'b111, "R5");       // set 1 still has room
    doLookup(1, 12'h011, 3'd1, 2'd0, "R5");
    doLookup(1, 12'h013, 3'd1, 2'd0, "R4");
    doLookup(1, 12'h014, 3'd1, 2'd1, "R7");             // dirty + referenced
    doLookup(1, 12'h012, 3'd1, 2'd2, "R7");             // referenced only

    for (int k = 0; k < 6; k++) begin
      doFill(12'h020 + 12'(2 * k), 3'(k % 3 + 1), 12'h100 + 12'(k), 3'b111, "R6");
      doLookup(1, lastEvVpn, lastEvPid, 2'd0, "R6");    // victim gone
      doLookup(1, 12'h020 + 12'(2 * k), 3'(k % 3 + 1), 2'(k % 2), "R6");
      for (int i = 0; i < MDEPTH; i++)
        if (mLive[i] && mVpn[i][0] == 1'b0 && (i % 2 == k % 2))
          doLookup(1, mVpn[i], mPid[i], 2'd1, "R6");    // survivors still hit
    end

    doFlush(1'b0);
    doLookup(1, 12'h011, 3'd1, 2'd0, "R9");
    doLookup(1, lastEvVpn, lastEvPid, 2'd0, "R9");
    doFill(12'h030, 3'd1, 12'h0AA, 3'b001, "R9");       // no writeback after flush
    doLookup(1, 12'h030, 3'd1, 2'd0, "R9");
    doFlush(1'b1);                                       // fill in flush cycle ignored
    doLookup(1, 12'h040, 3'd1, 2'd0, "R9");
    doLookup(1, 12'h030, 3'd1, 2'd0, "R9");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule